// File: doc/BRIEF.md
# SPI Flash Command Engine with Host Byte Registers

This block is an SPI flash master driven through a window of eight byte-wide host registers. Software fills an opcode register, three address registers and a trailing data register, then writes a control byte. That control write starts a command. Its fields select how many bytes go out, how many response bytes come back, and which serial clock rate is used. The engine shifts the outgoing bytes in SPI mode 0, most significant bit first, and keeps chip select low for the whole command. It then clocks in up to three response bytes, which the host reads back from the upper registers. A busy flag in the control register can be polled at any time.

Outgoing length is given by a compact two-bit code rather than a byte count. The address registers go onto the wire in descending offset order. A second start code opens a streaming session: the engine sends only the opcode and then keeps chip select asserted until software writes zero to the control register. The serial clock comes from the system clock. Two parameters set its half period for the fast and slow rates.

Top module: `spiCmdEngine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, offset 0 reads 0x00 and offsets 5, 6 and 7 read 0x00.
- R2: Reading offset 0 returns the busy flag in bit 7 and zeros in bits 6:0. Busy is 1 on the clock after an accepted start write. Busy returns to 0 on the same edge that chip select goes high.
- R3: A control write with bits 7:4 equal to 0x4 or 0x5 starts a command. Control bits 1:0 are the length code, and codes 0, 1, 2 and 3 send 1, 2, 4 and 5 bytes respectively.
- R4: The first byte sent is always the value at offset 1. Code 1 then sends offset 7. Codes 2 and 3 then send offsets 4, 3 and 2, and code 3 adds offset 7 last.
- R5: Transfers use SPI mode 0. The clock idles low, data on the MOSI line changes only while the clock is low, bits go out most significant first, and the MISO line is sampled on rising edges.
- R6: Control bits 3:2 give a read count of 0 to 3. That many bytes are clocked in after the outgoing bytes, with the MOSI line held at 0. They are stored in arrival order at offsets 5, 6 and 7. Offsets that receive no byte keep their contents.
- R7: Control bit 4 selects the rate. When it is 1, the serial clock half period is FAST_HALF system clocks. When it is 0, the half period is SLOW_HALF system clocks.
- R8: While busy, any control write is ignored except the zero write that ends a streaming session. Host writes to offsets 1 to 7 are also ignored while busy.
- R9: While idle, a control write whose bits 7:4 are not 0x2, 0x3, 0x4 or 0x5 starts nothing.
- R10: A control write with bits 7:4 equal to 0x2 or 0x3 sends the opcode at offset 1 and then keeps chip select low with busy set. Bit 4 still selects the rate. A later control write of 0x00 raises chip select and clears busy on the next clock.
- R11: Chip select stays low without a break from the first bit of a command to its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register offset for host reads and writes |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Read data for the offset on hostAddr |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the host issues at most one write per cycle and that software does not write a register it is reading in the same cycle. They also assume that the MISO line only has to be valid at the rising serial clock edges; its value at any other time is not relied on. The stimulus meets these assumptions. All host accesses go through tasks that change inputs on the falling system clock edge. The bench's flash model updates MISO only on a chip-select fall or a serial-clock fall. Every control value in the stimulus table decodes to a legal length code and read count. The deliberately illegal and mid-transfer writes are kept to the directed tests.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;

  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic       loadByte;   // load shifter from register loadSel (0 means all zeros)
    logic [2:0] loadSel;
    logic       sampleRise; // capture MISO at this rising serial edge
    logic       shiftFall;  // advance shifter at this falling serial edge
    logic       storeRx;    // commit completed response byte
    logic [1:0] rxIdx;      // response slot, 0 -> offset 5
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_TAIL,
    ST_HOLD
  } engState_e;

  // Number of outgoing bytes for each compact length code.
  function automatic logic [3:0] wrCount(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd5;
    endcase
  endfunction

  // Register offset that supplies outgoing byte number idx.
  function automatic logic [2:0] srcOffset(input logic [1:0] code, input logic [3:0] idx);
    logic [2:0] sel;
    sel = 3'd1;
    if (idx != 4'd0) begin
      if (code == 2'd1) sel = 3'd7;
      else if (idx == 4'd4) sel = 3'd7;
      else sel = 3'(5 - idx);
    end
    return sel;
  endfunction

endpackage

// File: rtl/spiCmdCtrl.sv
module spiCmdCtrl
  import spiCmdPkg::*;
#(
  parameter int FAST_HALF = 3,
  parameter int SLOW_HALF = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWrData,
  output dpStrobe_t  strobe,
  output logic       sclk,
  output logic       csN,
  output logic       busy
);

  localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int DIV_W    = $clog2(MAX_HALF + 1);
  localparam int BYTE_W   = 4;

  engState_e         state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfLen;
  logic              fastQ;
  logic              streamQ;
  logic [1:0]        codeQ;
  logic [BYTE_W-1:0] wrQ;
  logic [BYTE_W-1:0] totQ;
  logic [BYTE_W-1:0] byteIdx;
  logic [BYTE_W-1:0] nextIdx;
  logic [2:0]        bitCnt;
  logic              sclkQ;

  logic ctrlWr, startCmd, startStream, stopStream, tick;
  logic [3:0] ctrlHi;

  assign ctrlHi      = hostWrData[7:4];
  assign ctrlWr      = hostWrEn && (hostAddr == 3'd0);
  assign startCmd    = (state == ST_IDLE) && ctrlWr && (ctrlHi == 4'h4 || ctrlHi == 4'h5);
  assign startStream = (state == ST_IDLE) && ctrlWr && (ctrlHi == 4'h2 || ctrlHi == 4'h3);
  assign stopStream  = (state == ST_HOLD) && ctrlWr && (hostWrData == 8'h00);
  assign halfLen     = fastQ ? DIV_W'(FAST_HALF) : DIV_W'(SLOW_HALF);
  assign tick        = (divCnt == halfLen - DIV_W'(1));
  assign nextIdx     = byteIdx + BYTE_W'(1);

  always_comb begin
    strobe = '0;
    if (startCmd || startStream) begin
      strobe.loadByte = 1'b1;
      strobe.loadSel  = 3'd1;
    end
    if (state == ST_BITS && tick) begin
      if (!sclkQ) begin
        strobe.sampleRise = 1'b1;
      end else begin
        strobe.shiftFall = 1'b1;
        if (bitCnt == 3'd7) begin
          if (byteIdx >= wrQ) begin
            strobe.storeRx = 1'b1;
            strobe.rxIdx   = 2'(byteIdx - wrQ);
          end
          if (nextIdx != totQ) begin
            strobe.loadByte = 1'b1;
            strobe.loadSel  = (nextIdx < wrQ) ? srcOffset(codeQ, nextIdx) : 3'd0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      fastQ   <= 1'b0;
      streamQ <= 1'b0;
      codeQ   <= '0;
      wrQ     <= '0;
      totQ    <= '0;
      byteIdx <= '0;
      bitCnt  <= '0;
      sclkQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          divCnt  <= '0;
          byteIdx <= '0;
          bitCnt  <= '0;
          sclkQ   <= 1'b0;
          if (startCmd) begin
            fastQ   <= hostWrData[4];
            codeQ   <= hostWrData[1:0];
            wrQ     <= wrCount(hostWrData[1:0]);
            totQ    <= wrCount(hostWrData[1:0]) + BYTE_W'(hostWrData[3:2]);
            streamQ <= 1'b0;
            state   <= ST_LEAD;
          end else if (startStream) begin
            fastQ   <= hostWrData[4];
            codeQ   <= 2'd0;
            wrQ     <= BYTE_W'(1);
            totQ    <= BYTE_W'(1);
            streamQ <= 1'b1;
            state   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_BITS;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_BITS: begin
          if (tick) begin
            divCnt <= '0;
            sclkQ  <= !sclkQ;
            if (sclkQ) begin
              if (bitCnt == 3'd7) begin
                bitCnt <= '0;
                if (nextIdx == totQ) state <= streamQ ? ST_HOLD : ST_TAIL;
                else byteIdx <= nextIdx;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (tick) state <= ST_IDLE;
          else divCnt <= divCnt + DIV_W'(1);
        end
        ST_HOLD: begin
          if (stopStream) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign csN  = (state == ST_IDLE);
  assign busy = (state != ST_IDLE);

  AST_SCLK_LOW_OFF: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R5
  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS) |-> (byteIdx < totQ)); // R3
  AST_BUSY_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd || startStream) |=> (busy && !csN)); // R2
  AST_HOLD_KEEPS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !stopStream) |=> !csN); // R10
  AST_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS && ctrlWr) |=> (state == ST_BITS || state == ST_TAIL || state == ST_HOLD)); // R8

endmodule

// File: rtl/spiCmdDatapath.sv
module spiCmdDatapath
  import spiCmdPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [2:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              miso,
  output logic              mosi
);

  localparam int RX_BASE = 5;

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] shiftNext;
  logic              sampleQ;

  assign shiftNext = {shiftQ[DATA_W-2:0], sampleQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      sampleQ <= 1'b0;
    end else begin
      if (strobe.sampleRise) sampleQ <= miso;
      if (strobe.loadByte)
        shiftQ <= (strobe.loadSel == 3'd0) ? '0 : regFile[strobe.loadSel];
      else if (strobe.shiftFall)
        shiftQ <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
    end else begin
      for (int k = 1; k < NUM_REGS; k++) begin
        if (strobe.storeRx && (k == RX_BASE + int'(strobe.rxIdx)))
          regFile[k] <= shiftNext;
        else if (hostWrEn && !busy && (hostAddr == 3'(k)) && k != RX_BASE && k != RX_BASE + 1)
          regFile[k] <= hostWrData;
      end
    end
  end

  assign hostRdData = (hostAddr == 3'd0) ? {busy, {(DATA_W-1){1'b0}}} : regFile[hostAddr];
  assign mosi       = shiftQ[DATA_W-1];

  AST_BUSY_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn && hostAddr != 3'd0 && !strobe.storeRx)
    |=> (regFile[$past(hostAddr)] == $past(regFile[hostAddr]))); // R8
  AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeRx |-> (strobe.rxIdx != 2'd3)); // R6
  AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadByte |-> (strobe.loadSel != 3'd5 && strobe.loadSel != 3'd6)); // R4

endmodule

// File: rtl/spiCmdEngine.sv
module spiCmdEngine
  import spiCmdPkg::*;
#(
  parameter int FAST_HALF = 3,
  parameter int SLOW_HALF = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       spiSclk,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);

  dpStrobe_t strobe;
  logic      busy;

  spiCmdCtrl #(
    .FAST_HALF(FAST_HALF),
    .SLOW_HALF(SLOW_HALF)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .strobe    (strobe),
    .sclk      (spiSclk),
    .csN       (spiCsN),
    .busy      (busy)
  );

  spiCmdDatapath #(
    .DATA_W  (8),
    .NUM_REGS(8)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .strobe    (strobe),
    .busy      (busy),
    .miso      (spiMiso),
    .mosi      (spiMosi)
  );

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSclk && $past(spiSclk)) |-> $stable(spiMosi)); // R5
  AST_CS_RISE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> (hostRdData[7] == 1'b0 || hostAddr != 3'd0)); // R2

endmodule

// File: tb/spiCmdEngine_test.sv
`timescale 1ns/1ps
module spiCmdEngine_test;

  localparam int FAST_HALF = 3;
  localparam int SLOW_HALF = 6;
  localparam int NVEC = 8;
  // {control byte, expected outgoing byte count}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h40, 4'd1}, {8'h51, 4'd2}, {8'h46, 4'd4}, {8'h5B, 4'd5},
    {8'h4F, 4'd5}, {8'h52, 4'd4}, {8'h4C, 4'd1}, {8'h5D, 4'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;

  always #2.5 clk = ~clk;

  spiCmdEngine #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int total = 0;
  int failed = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] mosiBytes [8];
  int bitCount = 0;
  int csRises = 0;
  realtime tRise0, tRise1;

  function automatic logic [7:0] resp(input logic [7:0] s, input int n);
    return 8'h5A ^ 8'(n * 8'h13) ^ s;
  endfunction

  // flash model: drives MISO on CS fall and serial clock fall
  always @(negedge spiCsN) begin
    bitCount = 0;
    spiMiso = resp(seed, 0)[7];
  end
  always @(posedge spiCsN) csRises++;
  always @(posedge spiSclk) begin
    if (!spiCsN && bitCount < 64) begin
      mosiBytes[bitCount / 8][7 - (bitCount % 8)] = spiMosi;
      if (bitCount == 0) tRise0 = $realtime;
      if (bitCount == 1) tRise1 = $realtime;
      bitCount++;
    end
  end
  always @(negedge spiSclk) begin
    if (!spiCsN) spiMiso = resp(seed, bitCount / 8)[7 - (bitCount % 8)];
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int n = 0; n < 4000; n++) begin
      hostRead(3'd0, st);
      if (!st[7]) break;
    end
  endtask

  function automatic logic [2:0] expOffset(input logic [1:0] code, input int k);
    if (k == 0) return 3'd1;
    if (code == 2'd1) return 3'd7;
    if (k == 4) return 3'd7;
    return 3'(5 - k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(spiCsN == 1'b1, "R1 csN", int'(spiCsN), 1);
    check(spiSclk == 1'b0, "R1 sclk", int'(spiSclk), 0);
    hostRead(3'd0, rd); check(rd == 8'h00, "R1 status", rd, 0);
    hostRead(3'd5, rd); check(rd == 8'h00, "R1 rx0", rd, 0);
    hostRead(3'd7, rd); check(rd == 8'h00, "R1 rx2", rd, 0);

    // table walk: R3 R4 R6 R7 R11
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] ctl;
      int wr, rdn, half;
      ctl = VEC[v][11:4];
      wr = int'(VEC[v][3:0]);
      rdn = int'(ctl[3:2]);
      half = ctl[4] ? FAST_HALF : SLOW_HALF;
      seed = 8'(v * 37);
      for (int k = 1; k < 8; k++)
        if (k != 5 && k != 6) hostWrite(3'(k), 8'(16 * k + v));
      csRises = 0;
      hostWrite(3'd0, ctl);
      waitIdle();
      check(bitCount == 8 * (wr + rdn), "R3 bit count", bitCount, 8 * (wr + rdn));
      check(csRises == 1, "R11 single cs window", csRises, 1);
      for (int k = 0; k < wr; k++)
        check(mosiBytes[k] == 8'(16 * int'(expOffset(ctl[1:0], k)) + v), "R4 out byte",
              mosiBytes[k], 16 * int'(expOffset(ctl[1:0], k)) + v);
      for (int j = 0; j < rdn; j++) begin
        check(mosiBytes[wr + j] == 8'h00, "R6 mosi low on read", mosiBytes[wr + j], 0);
        hostRead(3'(5 + j), rd);
        check(rd == resp(seed, wr + j), "R6 rx byte", rd, resp(seed, wr + j));
      end
      if (rdn < 3) begin
        hostRead(3'd7, rd);
        check(rd == 8'(16 * 7 + v), "R6 offset 7 kept", rd, 16 * 7 + v);
      end
      check(int'(tRise1 - tRise0) == 10 * half, "R7 period", int'(tRise1 - tRise0), 10 * half);
    end

    // R9 illegal start codes
    hostWrite(3'd0, 8'h80);
    repeat (20) @(negedge clk);
    check(spiCsN == 1'b1, "R9 code 8 ignored", int'(spiCsN), 1);
    hostWrite(3'd0, 8'h10);
    repeat (20) @(negedge clk);
    hostRead(3'd0, rd);
    check(rd == 8'h00 && spiCsN, "R9 code 1 ignored", rd, 0);

    // R2 busy timing, R8 writes during busy
    hostWrite(3'd1, 8'hA5);
    seed = 8'h11;
    hostWrite(3'd0, 8'h40);
    #1 check(hostRdData == 8'h80 || hostAddr != 3'd0, "R2 busy next clock", hostRdData, 8'h80);
    hostRead(3'd0, rd); check(rd == 8'h80, "R2 busy read", rd, 8'h80);
    hostWrite(3'd0, 8'h4F);
    hostWrite(3'd1, 8'hEE);
    waitIdle();
    check(spiCsN == 1'b1, "R2 cs high when idle", int'(spiCsN), 1);
    check(bitCount == 8, "R8 second start ignored", bitCount, 8);
    hostRead(3'd1, rd); check(rd == 8'hA5, "R8 reg write ignored", rd, 8'hA5);
    repeat (40) @(negedge clk);
    check(spiCsN == 1'b1, "R8 no late start", int'(spiCsN), 1);

    // R10 streaming session
    hostWrite(3'd1, 8'hD8);
    hostWrite(3'd0, 8'h30);
    repeat (200) @(negedge clk);
    hostRead(3'd0, rd);
    check(rd == 8'h80, "R10 busy held", rd, 8'h80);
    check(spiCsN == 1'b0, "R10 cs held", int'(spiCsN), 0);
    check(bitCount == 8 && mosiBytes[0] == 8'hD8, "R10 opcode only", mosiBytes[0], 8'hD8);
    check(int'(tRise1 - tRise0) == 10 * FAST_HALF, "R10 fast rate", int'(tRise1 - tRise0), 10 * FAST_HALF);
    hostWrite(3'd0, 8'h25);
    repeat (20) @(negedge clk);
    check(spiCsN == 1'b0 && bitCount == 8, "R8 nonzero write in stream ignored", int'(spiCsN), 0);
    hostWrite(3'd0, 8'h00);
    check(spiCsN == 1'b1, "R10 stop raises cs", int'(spiCsN), 1);
    hostRead(3'd0, rd); check(rd == 8'h00, "R10 busy cleared", rd, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule